// File: doc/BRIEF.md
# Multiplexed Display RAM Scanner

This block keeps a bit map of segment states, one bit per segment column and per backplane row, and walks through its rows in step with the backplane phase of a liquid crystal display. Each phase it hands the output stage a full-width word of segment on/off bits for the backplane that is currently active, together with the index of that backplane. The number of rows scanned follows the multiplex mode: one backplane (static), two, three or four.

A host writes one column at a time: a column number and a 4-bit nibble that covers every row of that column. A phase tick from the timing logic moves the scan forward. In static and two-backplane modes, an output bank selection can show the upper rows in place of the lower ones. A swap input from the blink logic flips that selection while it is high. A blank input turns every segment off without disturbing the scan. Rows, mode and bank are taken at a tick, so within one phase the displayed word never changes and never mixes old and new data.

Top module: `lcd_ram_scanner`

## Requirements
- R1: After reset every stored bit is 0, `bp_idx` is 0 and `seg_out` is all zeros; the scan starts in the static state.
- R2: A cycle with `wr_en` high stores `wr_data[r]` as the bit of row r in column `wr_col`. A stored 1 means the element is on and shows as `seg_out[wr_col]` = 1 while that row is displayed; a 0 shows as off.
- R3: `mode` is encoded 0 = static, 1 = two backplanes, 2 = three backplanes, 3 = four backplanes (N = mode + 1 rows). Each cycle with `phase_tick` high moves `bp_idx` to `bp_idx`+1, or to 0 when `bp_idx`+1 reaches N.
- R4: In static mode `bp_idx` stays 0 on every tick.
- R5: `bp_idx` and `seg_out` change only at the clock edge that samples `phase_tick` high. After that edge `seg_out[c]` is the stored bit of column c in the row chosen for the new `bp_idx`.
- R6: The effective bank is `bank_sel` XOR `bank_swap`, sampled at the tick. In static and two-backplane modes with effective bank 1, the displayed row is `bp_idx` + 2, so row 2 replaces row 0 and row 3 replaces row 1.
- R7: In three- and four-backplane modes, `bank_sel` and `bank_swap` have no effect: the displayed row equals `bp_idx`.
- R8: While `blank` is high, `seg_out` is all zeros in the same cycle; the scan still advances, and when `blank` falls the word for the current phase appears.
- R9: A write does not alter `seg_out` before the next tick. A write in the same cycle as a tick is shown from the tick after that one.
- R10: A change of `mode` takes effect at the next tick. If `bp_idx`+1 is not below the new row count, the scan goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one column |
| wr_col | input | 5 | Column to write |
| wr_data | input | 4 | Row bits of that column (bit r = row r) |
| mode | input | 2 | Multiplex mode, encoded as in R3 |
| bank_sel | input | 1 | Output bank selection |
| bank_swap | input | 1 | Inverts the bank selection while high |
| blank | input | 1 | Forces all segment outputs off |
| phase_tick | input | 1 | Advance to the next backplane phase |
| bp_idx | output | 2 | Index of the active backplane |
| seg_out | output | 32 | Segment on/off bits for the active backplane |

## Verification
On every cycle the assertions check the following. Each write lands in the addressed column. A tick steps the phase by one or wraps it within the row count of the mode in force. Static mode holds the phase at 0. A blanked tick still moves the scan. The displayed word holds steady between ticks. Only the directed scenarios can show which row is selected, because that needs stored data to compare against: the bank substitution in static and two-backplane modes, the bank inputs being ignored in the larger modes, the late visibility of writes, and a mode change from a high phase.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ROWS = 4;
  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } mux_mode_e;

  // Number of backplane rows scanned in a mode.
  function automatic logic [PH_W:0] rows_in_mode(input logic [1:0] m);
    return {1'b0, m} + 3'd1;
  endfunction

  // Phase after a tick, with wrap inside the mode's row count.
  function automatic logic [PH_W-1:0] step_phase(input logic [PH_W-1:0] ph,
                                                 input logic [1:0] m);
    if (({1'b0, ph} + 3'd1) >= rows_in_mode(m)) return '0;
    return ph + 2'd1;
  endfunction

  // RAM row shown for a phase; the upper bank applies only in the small modes.
  function automatic logic [PH_W-1:0] shown_row(input logic [PH_W-1:0] ph,
                                                input logic [1:0] m,
                                                input logic upper);
    if (upper && (m == MODE_STATIC || m == MODE_MUX2)) return ph + 2'd2;
    return ph;
  endfunction
endpackage

// File: rtl/lcd_seg_ram.sv
module lcd_seg_ram
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 32,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [COL_W-1:0]    wr_col,
  input  logic [ROWS-1:0]     wr_data,
  input  logic [PH_W-1:0]     rd_row,
  output logic [NUM_COLS-1:0] rd_bits
);
  logic [ROWS-1:0] mem [NUM_COLS];
  logic            wr_hit;

  assign wr_hit = wr_en && (32'(wr_col) < NUM_COLS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_COLS; c++) mem[c] <= '0;
    end else if (wr_hit) begin
      mem[wr_col] <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign rd_bits[c] = mem[c][rd_row];
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> mem[$past(wr_col)] == $past(wr_data));
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      mode,
  output logic [PH_W-1:0] phase,
  output logic [PH_W-1:0] nxt_phase,
  output logic            wrap_evt
);
  assign nxt_phase = step_phase(phase, mode);
  assign wrap_evt  = tick && (nxt_phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= nxt_phase;
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (({1'b0, phase} + 3'd1) < rows_in_mode(mode))
      |=> phase == $past(phase) + 2'd1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ({1'b0, phase} == rows_in_mode(mode) - 3'd1) |=> phase == '0);

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> {1'b0, phase} < rows_in_mode($past(mode)));

  p_static_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (mode == MODE_STATIC) |=> phase == '0);
endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         blank,
  output logic [W-1:0] dout
);
  logic [W-1:0] seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seg_q <= '0;
    else if (load) seg_q <= din;
  end

  assign dout = blank ? '0 : seg_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_q));
endmodule

// File: rtl/lcd_ram_scanner.sv
module lcd_ram_scanner
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 32,
  localparam int COL_W = $clog2(NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [COL_W-1:0]    wr_col,
  input  logic [ROWS-1:0]     wr_data,
  input  logic [1:0]          mode,
  input  logic                bank_sel,
  input  logic                bank_swap,
  input  logic                blank,
  input  logic                phase_tick,
  output logic [PH_W-1:0]     bp_idx,
  output logic [NUM_COLS-1:0] seg_out
);
  logic [PH_W-1:0]     nxt_phase;
  logic                wrap_evt;
  logic                upper_bank;
  logic [PH_W-1:0]     rd_row;
  logic [NUM_COLS-1:0] rd_bits;

  assign upper_bank = bank_sel ^ bank_swap;
  assign rd_row     = shown_row(nxt_phase, mode, upper_bank);

  lcd_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(phase_tick), .mode(mode),
    .phase(bp_idx), .nxt_phase(nxt_phase), .wrap_evt(wrap_evt)
  );

  lcd_seg_ram #(.NUM_COLS(NUM_COLS)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col),
    .wr_data(wr_data), .rd_row(rd_row), .rd_bits(rd_bits)
  );

  lcd_row_latch #(.W(NUM_COLS)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(phase_tick), .din(rd_bits),
    .blank(blank), .dout(seg_out)
  );

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> bp_idx == '0);

  p_blank_keeps_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blank && phase_tick && (mode != MODE_STATIC) && ({1'b0, bp_idx} + 3'd1 < rows_in_mode(mode))
      |=> bp_idx != $past(bp_idx));
endmodule

// File: tb/lcd_ram_scanner_test.sv
module lcd_ram_scanner_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 32;

  logic clk = 0, rst_n = 0, wr_en = 0, bank_sel = 0, bank_swap = 0, blank = 0, phase_tick = 0;
  logic [4:0] wr_col = '0;
  logic [3:0] wr_data = '0;
  logic [1:0] mode = 2'd0;
  logic [1:0] bp_idx;
  logic [NC-1:0] seg_out;

  int n_checks = 0, n_fail = 0, exp_ph = 0;
  bit done = 0;
  logic [3:0] bm [NC];
  logic [NC-1:0] exp_latched = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_ram_scanner uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_data(wr_data),
    .mode(mode), .bank_sel(bank_sel), .bank_swap(bank_swap), .blank(blank),
    .phase_tick(phase_tick), .bp_idx(bp_idx), .seg_out(seg_out)
  );

  function automatic int count_for(logic [1:0] m);
    case (m)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [NC-1:0] pattern_of(int row);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = bm[c][row];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    logic [NC-1:0] e;
    e = blank ? '0 : exp_latched;
    check(bp_idx == 2'(exp_ph), req, 64'(bp_idx), 64'(exp_ph));
    check(seg_out == e, req, 64'(seg_out), 64'(e));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < NC; c++) bm[c] = '0;
    exp_ph = 0;
    exp_latched = '0;
    @(negedge clk);
  endtask

  task automatic tick();
    int row;
    @(negedge clk);
    phase_tick = 1;
    @(negedge clk);
    phase_tick = 0;
    exp_ph = (exp_ph + 1 >= count_for(mode)) ? 0 : exp_ph + 1;
    row = ((mode == 2'd0 || mode == 2'd1) && (bank_sel != bank_swap)) ? exp_ph + 2 : exp_ph;
    exp_latched = pattern_of(row);
  endtask

  task automatic write_col(int col, logic [3:0] d);
    @(negedge clk);
    wr_en = 1; wr_col = 5'(col); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    bm[col] = d;
  endtask

  task automatic fill();
    for (int c = 0; c < NC; c++) write_col(c, 4'((c * 7 + 3) ^ (c >> 2)));
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check_out("R1 reset");
  endtask

  // R2 R4 R5: static scan of row 0
  task automatic t_static();
    mode = 2'd0;
    fill();
    check_out("R9 no tick after writes");
    for (int i = 0; i < 3; i++) begin
      tick();
      check_out("R4 R2 R5 static");
    end
  endtask

  // R3 R5: the larger modes cycle through their rows
  task automatic t_modes();
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      tick();
      while (exp_ph != 0) tick();
      for (int i = 0; i < 2 * (m + 1); i++) begin
        tick();
        check_out("R3 R5 scan");
      end
    end
  endtask

  // R6 R7: bank selection and swap
  task automatic t_bank();
    mode = 2'd0; bank_sel = 1; bank_swap = 0;
    tick(); check_out("R6 static upper bank");
    bank_swap = 1;
    tick(); check_out("R6 swap cancels select");
    bank_sel = 0;
    tick(); check_out("R6 swap alone");
    bank_swap = 0; mode = 2'd1; bank_sel = 1;
    for (int i = 0; i < 4; i++) begin tick(); check_out("R6 mux2 upper bank"); end
    mode = 2'd3;
    for (int i = 0; i < 4; i++) begin tick(); check_out("R7 mux4 bank ignored"); end
    mode = 2'd2; bank_swap = 1; bank_sel = 0;
    for (int i = 0; i < 3; i++) begin tick(); check_out("R7 mux3 swap ignored"); end
    bank_sel = 0; bank_swap = 0;
  endtask

  // R8: blank
  task automatic t_blank();
    mode = 2'd3;
    blank = 1;
    @(negedge clk);
    check_out("R8 blank immediate");
    tick(); check_out("R8 blank scan advances");
    tick(); check_out("R8 blank scan advances");
    blank = 0;
    @(negedge clk);
    check_out("R8 blank release");
  endtask

  // R9: write timing
  task automatic t_write_timing();
    logic [3:0] old;
    logic [NC-1:0] shown;
    mode = 2'd3;
    shown = exp_latched;
    write_col(5, ~bm[5]);
    check(seg_out == shown, "R9 write hidden before tick", 64'(seg_out), 64'(shown));
    @(negedge clk);
    old = bm[9];
    wr_en = 1; wr_col = 5'd9; wr_data = ~old; phase_tick = 1;
    @(negedge clk);
    wr_en = 0; phase_tick = 0;
    exp_ph = (exp_ph + 1 >= 4) ? 0 : exp_ph + 1;
    exp_latched = pattern_of(exp_ph);
    check_out("R9 same-cycle write not shown");
    bm[9] = ~old;
    for (int i = 0; i < 4; i++) begin tick(); check_out("R9 write shown later"); end
  endtask

  // R10: mode change from a high phase
  task automatic t_mode_change();
    mode = 2'd3;
    while (exp_ph != 2) tick();
    mode = 2'd1;
    tick(); check_out("R10 mux4 to mux2 wraps");
    check(bp_idx == 2'd0, "R10 wrap index", 64'(bp_idx), 64'd0);
    mode = 2'd3;
    while (exp_ph != 1) tick();
    mode = 2'd2;
    tick(); check_out("R10 mux4 to mux3 steps");
  endtask

  // R1: reset mid-run clears stored data
  task automatic t_reset_clears();
    mode = 2'd3;
    do_reset();
    check_out("R1 reset mid run");
    for (int i = 0; i < 4; i++) begin tick(); check_out("R1 cleared rows"); end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) bm[c] = '0;
    t_reset();
    t_static();
    t_modes();
    t_bank();
    t_blank();
    t_write_timing();
    t_mode_change();
    t_reset_clears();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule